// File: doc/BRIEF.md
# Windowed-Fold Pipelined Modular Reducer

This block takes a wide integer, normally the 60-bit product of a 30 × 30 multiplier, and returns its residue modulo one of two 30-bit moduli. Each operand carries a one-bit select that picks the modulus, so one arithmetic lane can serve two residue channels and switch between them from one cycle to the next. The block accepts one operand on every clock cycle with no stalls, and it returns results in order after a fixed latency.

The reduction uses no multiplier. A chain of fold stages each takes a 6-bit window from the top of the current value. The window `w` indexes a 64-entry table that holds `w·2^30 mod q`. The table entry is shifted back to the window's weight and added to the bits below the window. Each fold shrinks the value by five bits. After six folds the value fits in 31 bits and is below `q + 2^30`. A last stage forms `x − q` and `x − 2q` side by side and keeps the smallest result that is not negative. Both tables are computed from the modulus parameters when the design is elaborated. Every stage is separated by a register.

Top module: `slidewin_modred`

## Requirements
- R1: For every 60-bit `in_val`, the result `out_res` equals `in_val mod q`, where `q` is the modulus the operand selected.
- R2: Every valid result is strictly less than the selected modulus.
- R3: `in_psel` = 0 selects modulus Q0 and `in_psel` = 1 selects Q1, chosen per operand. Back-to-back operands with different selects are each reduced by their own modulus, and `out_psel` returns the select alongside the result.
- R4: An operand sampled on rising edge k appears on `out_vld`/`out_res`/`out_psel` right after edge k+6, a latency of 7 register stages with the default widths. A new operand is accepted on every cycle.
- R5: `out_vld` is high only in cycles that correspond to an accepted operand. A cycle with `in_vld` low produces a cycle with `out_vld` low, and results come out in input order.
- R6: Reset is synchronous and active high. An edge with `rst` high clears every stage, so `out_vld` is low on the following cycle and operands that were in flight are dropped.
- R7: The final correction is exact at its boundaries. This covers inputs of 0, q−1, q, q+1, 2q−1, 2q, 3q, (q−1)², 2^31−1 and 2^60−1. The outcomes of the last fold cover the cases where 0, q and 2q must be subtracted.
- R8: Every 6-bit window value at every bit position of the input reduces correctly, with or without ones in the bits below the window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Operand present this cycle |
| in_psel | input | 1 | Modulus select: 0 = Q0, 1 = Q1 |
| in_val | input | 60 | Operand to reduce |
| out_vld | output | 1 | Result present this cycle |
| out_psel | output | 1 | Modulus select that travelled with the result |
| out_res | output | 30 | Reduced residue |

## Verification
The bench puts every window value at every bit offset of the operand and alternates the modulus on each cycle. A table built for the wrong modulus would produce wrong residues. So would a fold shifted to the wrong weight, or a select that drifts one stage away from its data, and these errors would show up on alternate operands. Inputs near q, 2q and 3q, together with the largest values that fit in 31 bits, drive the final correction into each of its three choices. A correction that compares in the wrong order, or drops the 2q branch, would return a value at or above q. Idle gaps in the input stream and a reset in the middle of a stream check the valid alignment. A pipeline that loses or duplicates a valid bit, or that does not clear on reset, would produce a result in the wrong cycle.

// File: rtl/slidewin_pkg.sv
package slidewin_pkg;

    // Lane width carried between stages; wide enough for any supported operand.
    localparam int unsigned LANE_W = 64;

    typedef struct packed {
        logic              vld;
        logic              psel;
        logic [LANE_W-1:0] val;
    } lane_t;

    // Bit position of the window folded by a stage that sees a value of width w.
    function automatic int unsigned step_pos(int unsigned w, int unsigned qw, int unsigned win);
        return (w > qw + win) ? (w - win) : qw;
    endfunction

    // Number of fold stages needed to bring an in_w-bit value down to qw+1 bits.
    function automatic int unsigned fold_count(int unsigned in_w, int unsigned qw, int unsigned win);
        int unsigned w = in_w;
        int unsigned n = 0;
        while (w > qw + 1) begin
            w = step_pos(w, qw, win) + 1;
            n++;
        end
        return n;
    endfunction

    // Window position of fold stage idx.
    function automatic int unsigned fold_pos(int unsigned in_w, int unsigned qw, int unsigned win,
                                             int unsigned idx);
        int unsigned w = in_w;
        int unsigned p = qw;
        for (int unsigned k = 0; k <= idx; k++) begin
            p = step_pos(w, qw, win);
            w = p + 1;
        end
        return p;
    endfunction

endpackage

// File: rtl/slidewin_table.sv
module slidewin_table
    import slidewin_pkg::*;
#(
    parameter int unsigned    QW  = 30,
    parameter int unsigned    WIN = 6,
    parameter longint unsigned Q0 = 64'd1073741789,
    parameter longint unsigned Q1 = 64'd536903681
) (
    input  logic           psel,
    input  logic [WIN-1:0] idx,
    output logic [QW-1:0]  res
);
    localparam int unsigned N_ENT = 1 << WIN;

    logic [QW-1:0] tab_a [N_ENT];
    logic [QW-1:0] tab_b [N_ENT];

    // Entry e holds e * 2^QW reduced by each modulus, fixed at elaboration.
    for (genvar e = 0; e < N_ENT; e++) begin : g_ent
        assign tab_a[e] = QW'((64'(e) << QW) % Q0);
        assign tab_b[e] = QW'((64'(e) << QW) % Q1);
    end

    assign res = psel ? tab_b[idx] : tab_a[idx];

endmodule

// File: rtl/slidewin_fold.sv
module slidewin_fold
    import slidewin_pkg::*;
#(
    parameter int unsigned    POS = 54,
    parameter int unsigned    QW  = 30,
    parameter int unsigned    WIN = 6,
    parameter longint unsigned Q0 = 64'd1073741789,
    parameter longint unsigned Q1 = 64'd536903681
) (
    input  logic  clk,
    input  logic  rst,
    input  lane_t d,
    output lane_t q
);
    localparam logic [LANE_W-1:0] LOW_MASK = (LANE_W'(1) << POS) - LANE_W'(1);

    logic [WIN-1:0]    win_bits;
    logic [QW-1:0]     win_res;
    logic [LANE_W-1:0] folded;

    assign win_bits = d.val[POS +: WIN];

    slidewin_table #(
        .QW (QW),
        .WIN(WIN),
        .Q0 (Q0),
        .Q1 (Q1)
    ) u_tab (
        .psel(d.psel),
        .idx (win_bits),
        .res (win_res)
    );

    // Window w at weight 2^POS is congruent to (w*2^QW mod q) at weight 2^(POS-QW).
    assign folded = (LANE_W'(win_res) << (POS - QW)) + (d.val & LOW_MASK);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q.vld  <= d.vld;
            q.psel <= d.psel;
            q.val  <= folded;
        end
    end

endmodule

// File: rtl/slidewin_final.sv
module slidewin_final
    import slidewin_pkg::*;
#(
    parameter int unsigned    QW = 30,
    parameter longint unsigned Q0 = 64'd1073741789,
    parameter longint unsigned Q1 = 64'd536903681
) (
    input  logic          clk,
    input  logic          rst,
    input  lane_t         d,
    output logic          out_vld,
    output logic          out_psel,
    output logic [QW-1:0] out_res
);
    localparam int unsigned DW = QW + 2;

    logic [DW-1:0] x_ext;
    logic [DW-1:0] q_one;
    logic [DW-1:0] q_two;
    logic [DW-1:0] less_one;
    logic [DW-1:0] less_two;
    logic [QW-1:0] pick;

    assign x_ext    = {1'b0, d.val[QW:0]};
    assign q_one    = d.psel ? DW'(Q1) : DW'(Q0);
    assign q_two    = q_one << 1;
    assign less_one = x_ext - q_one;
    assign less_two = x_ext - q_two;

    // Both trial subtractions run in parallel; the smallest non-negative wins.
    always_comb begin
        if (!less_two[DW-1]) begin
            pick = less_two[QW-1:0];
        end else if (!less_one[DW-1]) begin
            pick = less_one[QW-1:0];
        end else begin
            pick = x_ext[QW-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld  <= 1'b0;
            out_psel <= 1'b0;
            out_res  <= '0;
        end else begin
            out_vld  <= d.vld;
            out_psel <= d.psel;
            out_res  <= pick;
        end
    end

endmodule

// File: rtl/slidewin_modred.sv
module slidewin_modred
    import slidewin_pkg::*;
#(
    parameter int unsigned    IN_W = 60,
    parameter int unsigned    QW   = 30,
    parameter int unsigned    WIN  = 6,
    parameter longint unsigned Q0  = 64'd1073741789,
    parameter longint unsigned Q1  = 64'd536903681
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_vld,
    input  logic            in_psel,
    input  logic [IN_W-1:0] in_val,
    output logic            out_vld,
    output logic            out_psel,
    output logic [QW-1:0]   out_res
);
    localparam int unsigned N_FOLD = fold_count(IN_W, QW, WIN);

    lane_t chain [N_FOLD+1];

    assign chain[0].vld  = in_vld;
    assign chain[0].psel = in_psel;
    assign chain[0].val  = LANE_W'(in_val);

    for (genvar i = 0; i < N_FOLD; i++) begin : g_fold
        slidewin_fold #(
            .POS(fold_pos(IN_W, QW, WIN, i)),
            .QW (QW),
            .WIN(WIN),
            .Q0 (Q0),
            .Q1 (Q1)
        ) u_fold (
            .clk(clk),
            .rst(rst),
            .d  (chain[i]),
            .q  (chain[i+1])
        );
    end

    slidewin_final #(
        .QW(QW),
        .Q0(Q0),
        .Q1(Q1)
    ) u_final (
        .clk     (clk),
        .rst     (rst),
        .d       (chain[N_FOLD]),
        .out_vld (out_vld),
        .out_psel(out_psel),
        .out_res (out_res)
    );

endmodule

// File: rtl/slidewin_modred_chk.sv
module slidewin_modred_chk
    import slidewin_pkg::*;
#(
    parameter int unsigned    IN_W = 60,
    parameter int unsigned    QW   = 30,
    parameter int unsigned    WIN  = 6,
    parameter longint unsigned Q0  = 64'd1073741789,
    parameter longint unsigned Q1  = 64'd536903681
) (
    input logic            clk,
    input logic            rst,
    input logic            in_vld,
    input logic            in_psel,
    input logic [IN_W-1:0] in_val,
    input logic            out_vld,
    input logic            out_psel,
    input logic [QW-1:0]   out_res
);
    localparam int unsigned LAT = fold_count(IN_W, QW, WIN) + 1;

    logic [LAT-1:0] vld_pipe;
    logic [LAT-1:0] sel_pipe;
    logic [QW-1:0]  res_pipe [LAT];

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_pipe <= '0;
            sel_pipe <= '0;
            for (int k = 0; k < LAT; k++) res_pipe[k] <= '0;
        end else begin
            vld_pipe    <= {vld_pipe[LAT-2:0], in_vld};
            sel_pipe    <= {sel_pipe[LAT-2:0], in_psel};
            res_pipe[0] <= QW'(64'(in_val) % (in_psel ? Q1 : Q0));
            for (int k = 1; k < LAT; k++) res_pipe[k] <= res_pipe[k-1];
        end
    end

    p_residue_r1: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> out_res == res_pipe[LAT-1]);

    p_below_mod_r2: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> 64'(out_res) < (out_psel ? Q1 : Q0));

    p_select_travel_r3: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> out_psel == sel_pipe[LAT-1]);

    p_fixed_latency_r4: assert property (@(posedge clk) disable iff (rst)
        out_vld == vld_pipe[LAT-1]);

    p_reset_clear_r6: assert property (@(posedge clk)
        $past(rst) |-> !out_vld);

endmodule

bind slidewin_modred slidewin_modred_chk #(
    .IN_W(IN_W),
    .QW  (QW),
    .WIN (WIN),
    .Q0  (Q0),
    .Q1  (Q1)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .in_vld  (in_vld),
    .in_psel (in_psel),
    .in_val  (in_val),
    .out_vld (out_vld),
    .out_psel(out_psel),
    .out_res (out_res)
);

// File: tb/slidewin_modred_test.sv
`timescale 1ns/1ps
module slidewin_modred_test;

    localparam longint unsigned Q0  = 64'd1073741789;
    localparam longint unsigned Q1  = 64'd536903681;
    localparam int              LAT = 7;
    localparam int              QDEPTH = 32768;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_vld = 1'b0;
    logic        in_psel = 1'b0;
    logic [59:0] in_val = '0;
    logic        out_vld;
    logic        out_psel;
    logic [29:0] out_res;

    always #4 clk = ~clk;

    slidewin_modred #(
        .IN_W(60), .QW(30), .WIN(6), .Q0(Q0), .Q1(Q1)
    ) uut (
        .clk(clk), .rst(rst), .in_vld(in_vld), .in_psel(in_psel), .in_val(in_val),
        .out_vld(out_vld), .out_psel(out_psel), .out_res(out_res)
    );

    int    compared = 0;
    int    mismatched = 0;
    int    cyc = 0;
    bit    mon_en = 1'b0;
    bit    done = 1'b0;
    int    head = 0;
    int    tail = 0;
    logic [29:0] e_res [QDEPTH];
    logic        e_sel [QDEPTH];
    int          e_due [QDEPTH];
    string       e_tag [QDEPTH];
    logic [63:0] rng = 64'h9E3779B97F4A7C15;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [29:0] ref_mod(input logic [59:0] v, input logic s);
        longint unsigned m = s ? Q1 : Q0;
        return 30'(64'(v) % m);
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic send(input logic [59:0] v, input logic s, input string tag);
        @(negedge clk);
        in_vld  = 1'b1;
        in_val  = v;
        in_psel = s;
        e_res[tail] = ref_mod(v, s);
        e_sel[tail] = s;
        e_due[tail] = cyc + LAT;
        e_tag[tail] = tag;
        tail++;
    endtask

    task automatic idle();
        @(negedge clk);
        in_vld  = 1'b0;
        in_val  = '1;
        in_psel = ~in_psel;
    endtask

    function automatic logic [63:0] next_rand(input logic [63:0] x);
        logic [63:0] y = x;
        y = y ^ (y << 13);
        y = y ^ (y >> 7);
        y = y ^ (y << 17);
        return y;
    endfunction

    // Scoreboard: R4/R5 valid timing, R1 value, R2 range, R3 select echo.
    always @(negedge clk) begin
        if (mon_en) begin
            bit due_now;
            due_now = (head < tail) && (e_due[head] == cyc);
            chk(out_vld === due_now, "R4 R5 out_vld", longint'(out_vld), longint'(due_now));
            if (due_now) begin
                chk(out_res === e_res[head], {"R1 ", e_tag[head], " out_res"},
                    longint'(out_res), longint'(e_res[head]));
                chk(64'(out_res) < (e_sel[head] ? Q1 : Q0), "R2 out_res below modulus",
                    longint'(out_res), longint'(e_sel[head] ? Q1 : Q0));
                chk(out_psel === e_sel[head], "R3 out_psel", longint'(out_psel),
                    longint'(e_sel[head]));
                head++;
            end
        end
    end

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL R4 watchdog actual=%0d expected=%0d", cyc, 0);
            report();
            $finish;
        end
    end

    initial begin
        // R6: reset state
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(out_vld === 1'b0, "R6 out_vld after reset", longint'(out_vld), 0);
        chk(out_res === '0, "R6 out_res after reset", longint'(out_res), 0);
        mon_en = 1'b1;

        // R7: correction boundaries for both moduli, back to back
        for (int s = 0; s < 2; s++) begin
            logic [59:0] qv;
            qv = 60'(s != 0 ? Q1 : Q0);
            send(60'd0, s[0], "R7");
            send(60'd1, s[0], "R7");
            send(qv - 60'd1, s[0], "R7");
            send(qv, s[0], "R7");
            send(qv + 60'd1, s[0], "R7");
            send(2 * qv - 60'd1, s[0], "R7");
            send(2 * qv, s[0], "R7");
            send(2 * qv + 60'd1, s[0], "R7");
            send(3 * qv, s[0], "R7");
            send((qv - 60'd1) * (qv - 60'd1), s[0], "R7");
            send(60'h7FFF_FFFF, s[0], "R7");
            send(60'h3FFF_FFFF, s[0], "R7");
            send(60'h4000_0000, s[0], "R7");
            send({60{1'b1}}, s[0], "R7");
            send(qv << 29, s[0], "R7");
        end
        idle();

        // R8 + R3: every window at every offset, alternating modulus each cycle
        for (int b = 0; b < 55; b++) begin
            for (int w = 0; w < 64; w++) begin
                logic [59:0] v;
                v = 60'(w) << b;
                if (w[0]) v = v | ((60'd1 << b) - 60'd1);
                send(v, logic'((b + w) & 1), "R8");
            end
        end

        // R1 + R5: random operands and products with idle gaps
        for (int n = 0; n < 4000; n++) begin
            rng = next_rand(rng);
            if (n % 7 == 3) begin
                idle();
            end else if (n % 2 == 0) begin
                send(rng[59:0], rng[63], "R1");
            end else begin
                send(60'(rng[29:0]) * 60'(rng[59:30]), rng[62], "R1");
            end
        end
        repeat (LAT + 3) idle();
        chk(head == tail, "R5 all results returned", longint'(head), longint'(tail));

        // R6: reset while operands are in flight drops them
        for (int n = 0; n < 5; n++) send(60'(n) * 60'd123456789, 1'b0, "R6");
        @(negedge clk);
        mon_en = 1'b0;
        rst    = 1'b1;
        in_vld = 1'b0;
        head   = tail;
        @(negedge clk);
        rst = 1'b0;
        for (int n = 0; n < LAT + 3; n++) begin
            @(negedge clk);
            chk(out_vld === 1'b0, "R6 in-flight operand dropped", longint'(out_vld), 0);
        end
        mon_en = 1'b1;

        // R4: results resume with correct latency after reset
        send(60'hFFF_FFFF_FFFF, 1'b1, "R4");
        send(60'h123_4567_89AB, 1'b0, "R4");
        repeat (LAT + 3) idle();
        chk(head == tail, "R4 results after reset", longint'(head), longint'(tail));

        done = 1'b1;
        report();
        $finish;
    end

endmodule